// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Command Controller

This block lets software reach the contents of a serial flash as if it were ordinary memory. A bus read or write arriving on the memory port is expanded into a complete single-lane SPI transaction. The controller selects the chip, sends an opcode chosen by the current mode, and sends the target address most significant byte first. Writes get a one-byte write-enable frame in front. Fast reads get a programmable number of dummy bytes. The data bytes follow in little-endian order. The address is first folded into a programmable power-of-two segment window. An address that lies outside the window is wrapped rather than refused, and the error flag is raised.

A small configuration port holds four registers: a control word, the segment size as log2 of the byte count, the SPI half-period divider and the fast-read dummy count. The chip select pin is driven straight from the control word's select-inactive bit. The sequencer clears that bit for the duration of a command transaction and sets it again afterwards. In pass-through mode the sequencer leaves the bit alone, so software frames the bus itself and each memory access only moves raw bytes. The memory port holds `mem_ready_o` low for as long as a transaction runs.

Top module: `spi_mmap_ctrl`

## Requirements
- R1: After reset `mem_ready_o`=1, `spi_cs_no`=1, `spi_sclk_o`=0 and `mem_err_o`=0. The configuration registers read back as follows: control (address 0) = 0x0000_0004, segment log2 (address 1) = 24, divider (address 2) = 1, dummy count (address 3) = 1.
- R2: Control bits [1:0] select the mode: 0 normal read, 1 fast read, 2 write, 3 pass-through. A read in mode 0 opens one chip-select frame carrying opcode 0x03, whatever control bits [23:16] hold. The opcode is followed by the address bytes and then one byte per requested data byte, with 0x00 sent on MOSI. Received byte i lands at `mem_rdata_o[8*i+7:8*i]`, and higher bytes read 0. Control bit 2 (the chip-select-inactive flag, driven onto `spi_cs_no`) reads 0 during the frame and 1 after it.
- R3: When control bit 13 is 1, four address bytes are sent; otherwise three. In both cases they are sent most significant byte first.
- R4: The address sent equals `mem_addr_i` AND (2^seg − 1), with the full address used when seg ≥ 32. `mem_err_o` is 1 after an access whose address changed under that mask, and 0 after a clean access. The access still runs.
- R5: A read in mode 1 sends opcode control[23:16], then the address, then the dummy count of 0x00 bytes (none when the count is 0), and only then the data bytes.
- R6: A write in mode 2 first sends 0x06 alone in its own frame. It then opens a second frame with opcode control[23:16], the address, and the data bytes least significant first (`mem_size_i`+1 bytes).
- R7: In mode 3 no opcode or address is sent and the chip select is not touched by the block. A write sends its data bytes least significant first. A read sends 0x00 bytes and returns the captured bytes as in R2.
- R8: A write in mode 0 or 1, or a read in mode 2, sets `mem_err_o`, keeps `mem_ready_o` high and produces no SPI clock.
- R9: The SPI bus runs in mode 0. SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the rising edge. Each SCLK level lasts divider+1 clock cycles.
- R10: An accepted access drops `mem_ready_o` on the next cycle and holds it low until the last byte has finished. When `mem_ready_o` returns high, `mem_rdata_o` and `mem_err_o` are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Selected configuration register |
| mem_req_i | input | 1 | Memory access request, taken while ready is high |
| mem_we_i | input | 1 | 1 for write, 0 for read |
| mem_addr_i | input | 32 | Byte address inside the flash |
| mem_size_i | input | 2 | Byte count minus one |
| mem_wdata_i | input | 32 | Write data, byte 0 sent first |
| mem_rdata_o | output | 32 | Read data |
| mem_ready_o | output | 1 | Idle / access complete |
| mem_err_o | output | 1 | Error flag for the last access |
| spi_sclk_o | output | 1 | SPI clock |
| spi_cs_no | output | 1 | SPI chip select, active low |
| spi_mosi_o | output | 1 | SPI data out |
| spi_miso_i | input | 1 | SPI data in |

## Verification
A window violation and a direction/mode mismatch can land on the same access, and both feed the error flag. The mismatch must still suppress the whole SPI sequence, while a lone violation must let the wrapped sequence run. The random phase draws narrow segment sizes together with random directions in every command mode, which produces both conditions, alone and together. Each access is judged by comparing the captured byte stream, its frame boundaries and the flag against the bench's own model of the transaction. A second coincidence is the release of chip select in the same cycle that ready returns; this is judged by sampling both, and the control bit, at the first idle cycle.

// File: rtl/spi_mmap_pkg.sv
package spi_mmap_pkg;
  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_FAST  = 2'd1,
    MD_WRITE = 2'd2,
    MD_USER  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WREN, PH_GAP, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA
  } phase_e;

  localparam int CSOFF_BIT = 2;
  localparam int A4_BIT    = 13;
  localparam int OP_LSB    = 16;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WREN = 8'h06;
endpackage

// File: rtl/spi_mmap_shift.sv
module spi_mmap_shift #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       tx_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             miso_i,
  output logic             done_o,
  output logic [7:0]       rx_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  logic             active_q, sclk_q, done_q;
  logic [7:0]       sh_q, rx_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
      sh_q <= '0; rx_q <= '0; bit_q <= '0; cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= 1'b1; sh_q <= tx_i; cnt_q <= '0; bit_q <= '0; sclk_q <= 1'b0;
      end else if (active_q) begin
        if (cnt_q == div_i) begin
          cnt_q <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = sh_q[7];
endmodule

// File: rtl/spi_mmap_seq.sv
module spi_mmap_seq
  import spi_mmap_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int DUM_W      = 3,
  localparam int DW   = 8 * DATA_BYTES,
  localparam int SZ_W = $clog2(DATA_BYTES),
  localparam int CW   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             we_i,
  input  mode_e            mode_i,
  input  logic [7:0]       op_i,
  input  logic             a4_i,
  input  logic [31:0]      addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [SZ_W-1:0]  nlast_i,
  input  logic [DUM_W-1:0] dum_i,
  input  logic             done_i,
  input  logic [7:0]       rx_i,
  output logic             start_o,
  output logic [7:0]       tx_o,
  output logic             cs_clr_o,
  output logic             cs_set_o,
  output logic             idle_o,
  output logic [DW-1:0]    rdata_o
);
  phase_e           ph_q;
  mode_e            mode_q;
  logic             we_q, a4_q, infl_q;
  logic [7:0]       op_q;
  logic [31:0]      addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic [SZ_W-1:0]  nlast_q;
  logic [DUM_W-1:0] dum_q;
  logic [CW-1:0]    cnt_q, alast;
  logic             byte_done, data_last;

  assign alast     = a4_q ? CW'(3) : CW'(2);
  assign byte_done = infl_q && done_i;
  assign data_last = (cnt_q == CW'(nlast_q));

  always_comb begin
    unique case (ph_q)
      PH_WREN: tx_o = OP_WREN;
      PH_CMD:  tx_o = op_q;
      PH_ADDR: tx_o = 8'(addr_q >> (8 * (alast - cnt_q)));
      PH_DATA: tx_o = we_q ? 8'(wdata_q >> (8 * cnt_q)) : 8'h00;
      default: tx_o = 8'h00;
    endcase
  end

  assign start_o  = !infl_q && (ph_q != PH_IDLE) && (ph_q != PH_GAP);
  assign cs_clr_o = (acc_i && mode_i != MD_USER) || (ph_q == PH_GAP);
  assign cs_set_o = byte_done && ((ph_q == PH_WREN) ||
                    (ph_q == PH_DATA && data_last && mode_q != MD_USER));
  assign idle_o   = (ph_q == PH_IDLE);
  assign rdata_o  = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; mode_q <= MD_READ; we_q <= 1'b0; a4_q <= 1'b0;
      infl_q <= 1'b0; op_q <= '0; addr_q <= '0; wdata_q <= '0;
      rdata_q <= '0; nlast_q <= '0; dum_q <= '0; cnt_q <= '0;
    end else if (acc_i) begin
      mode_q <= mode_i; we_q <= we_i; a4_q <= a4_i; op_q <= op_i;
      addr_q <= addr_i; wdata_q <= wdata_i; nlast_q <= nlast_i; dum_q <= dum_i;
      rdata_q <= '0; cnt_q <= '0; infl_q <= 1'b0;
      ph_q <= (mode_i == MD_USER)  ? PH_DATA :
              (mode_i == MD_WRITE) ? PH_WREN : PH_CMD;
    end else begin
      if (start_o) infl_q <= 1'b1;
      if (ph_q == PH_GAP) ph_q <= PH_CMD;
      if (byte_done) begin
        infl_q <= 1'b0;
        unique case (ph_q)
          PH_WREN: ph_q <= PH_GAP;
          PH_CMD: begin ph_q <= PH_ADDR; cnt_q <= '0; end
          PH_ADDR:
            if (cnt_q == alast) begin
              cnt_q <= '0;
              ph_q  <= (mode_q == MD_FAST && dum_q != '0) ? PH_DUMMY : PH_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          PH_DUMMY:
            if (cnt_q == CW'(dum_q) - 1'b1) begin cnt_q <= '0; ph_q <= PH_DATA; end
            else cnt_q <= cnt_q + 1'b1;
          PH_DATA: begin
            for (int i = 0; i < DATA_BYTES; i++)
              if (!we_q && cnt_q == CW'(i)) rdata_q[8*i +: 8] <= rx_i;
            if (data_last) ph_q <= PH_IDLE;
            else cnt_q <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_mmap_ctrl.sv
module spi_mmap_ctrl
  import spi_mmap_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int DIV_W      = 8,
  parameter int DUM_W      = 3,
  parameter int SEG_RST    = 24,
  parameter int DIV_RST    = 1,
  parameter int DUM_RST    = 1,
  localparam int DW   = 8 * DATA_BYTES,
  localparam int SZ_W = $clog2(DATA_BYTES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_addr_i,
  input  logic [31:0]     cfg_wdata_i,
  output logic [31:0]     cfg_rdata_o,
  input  logic            mem_req_i,
  input  logic            mem_we_i,
  input  logic [31:0]     mem_addr_i,
  input  logic [SZ_W-1:0] mem_size_i,
  input  logic [DW-1:0]   mem_wdata_i,
  output logic [DW-1:0]   mem_rdata_o,
  output logic            mem_ready_o,
  output logic            mem_err_o,
  output logic            spi_sclk_o,
  output logic            spi_cs_no,
  output logic            spi_mosi_o,
  input  logic            spi_miso_i
);
  logic [31:0]      ctrl_q;
  logic [5:0]       seg_q;
  logic [DIV_W-1:0] div_q;
  logic [DUM_W-1:0] dum_q;
  logic             err_q;
  mode_e            mode;
  logic             idle, take, mism, acc, cs_clr, cs_set, start, done;
  logic [32:0]      win;
  logic [31:0]      mask, maddr;
  logic [7:0]       op, tx, rx;

  assign mode  = mode_e'(ctrl_q[1:0]);
  assign win   = 33'(1) << seg_q;
  assign mask  = win[31:0] - 32'd1;
  assign maddr = mem_addr_i & mask;
  assign take  = mem_req_i && idle;
  assign mism  = mem_we_i ? (mode == MD_READ || mode == MD_FAST) : (mode == MD_WRITE);
  assign acc   = take && !mism;
  assign op    = (mode == MD_READ) ? OP_READ : ctrl_q[OP_LSB +: 8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 32'(1) << CSOFF_BIT;
      seg_q  <= 6'(SEG_RST);
      div_q  <= DIV_W'(DIV_RST);
      dum_q  <= DUM_W'(DUM_RST);
      err_q  <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        unique case (cfg_addr_i)
          2'd0: ctrl_q <= cfg_wdata_i;
          2'd1: seg_q  <= cfg_wdata_i[5:0];
          2'd2: div_q  <= cfg_wdata_i[DIV_W-1:0];
          default: dum_q <= cfg_wdata_i[DUM_W-1:0];
        endcase
      end
      if (cs_clr) ctrl_q[CSOFF_BIT] <= 1'b0;
      if (cs_set) ctrl_q[CSOFF_BIT] <= 1'b1;
      if (take) err_q <= mism || (mode != MD_USER && maddr != mem_addr_i);
    end
  end

  always_comb begin
    unique case (cfg_addr_i)
      2'd0: cfg_rdata_o = ctrl_q;
      2'd1: cfg_rdata_o = 32'(seg_q);
      2'd2: cfg_rdata_o = 32'(div_q);
      default: cfg_rdata_o = 32'(dum_q);
    endcase
  end

  spi_mmap_seq #(.DATA_BYTES(DATA_BYTES), .DUM_W(DUM_W)) u_seq (
    .clk_i, .rst_ni, .acc_i(acc), .we_i(mem_we_i), .mode_i(mode), .op_i(op),
    .a4_i(ctrl_q[A4_BIT]), .addr_i(maddr), .wdata_i(mem_wdata_i),
    .nlast_i(mem_size_i), .dum_i(dum_q), .done_i(done), .rx_i(rx),
    .start_o(start), .tx_o(tx), .cs_clr_o(cs_clr), .cs_set_o(cs_set),
    .idle_o(idle), .rdata_o(mem_rdata_o)
  );

  spi_mmap_shift #(.DIV_W(DIV_W)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .tx_i(tx), .div_i(div_q),
    .miso_i(spi_miso_i), .done_o(done), .rx_o(rx),
    .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o)
  );

  assign mem_ready_o = idle;
  assign mem_err_o   = err_q;
  assign spi_cs_no   = ctrl_q[CSOFF_BIT];
endmodule

// File: rtl/spi_mmap_ctrl_chk.sv
module spi_mmap_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_i,
  input logic        mem_we_i,
  input logic        mem_ready_o,
  input logic        mem_err_o,
  input logic        spi_sclk_o,
  input logic        spi_cs_no,
  input logic        spi_mosi_o,
  input logic [31:0] ctrl_q
);
  logic wrong_dir;
  assign wrong_dir = mem_we_i ? (ctrl_q[1:0] == 2'd0 || ctrl_q[1:0] == 2'd1)
                              : (ctrl_q[1:0] == 2'd2);

  assert_sclk_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ready_o |-> !spi_sclk_o);

  assert_mosi_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sclk_o |-> $stable(spi_mosi_o));

  assert_cs_framed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ready_o && spi_sclk_o && ctrl_q[1:0] != 2'd3) |-> !spi_cs_no);

  assert_wrong_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_ready_o && wrong_dir) |=> (mem_ready_o && mem_err_o));

  assert_busy_after_take_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_ready_o && !wrong_dir) |=> !mem_ready_o);

  assert_err_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ready_o && $past(!mem_ready_o)) |-> $stable(mem_err_o));
endmodule

bind spi_mmap_ctrl spi_mmap_ctrl_chk u_chk (.*);

// File: tb/spi_mmap_ctrl_bench.sv
module spi_mmap_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic [1:0]  size = '0;
  logic        ready, err, sclk, cs_n, mosi, miso;

  always #10 clk = ~clk;

  spi_mmap_ctrl u_spi_mmap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .mem_req_i(req),
    .mem_we_i(we), .mem_addr_i(addr), .mem_size_i(size), .mem_wdata_i(wdata),
    .mem_rdata_o(rdata), .mem_ready_o(ready), .mem_err_o(err),
    .spi_sclk_o(sclk), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // flash side model: logs bytes with frame numbers, returns a pattern on MISO
  logic [7:0] log_b [0:4095];
  int         log_f [0:4095];
  int         log_n = 0, frame = 0, bc = 0, fe = 0;
  logic [7:0] sh = '0, cur_b;
  int         hi_run = 0, hi_min = 1000, hi_max = 0;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 55 + 29) & 255);
  endfunction

  always @(negedge cs_n) begin frame++; bc = 0; end
  always @(posedge sclk) begin
    sh = {sh[6:0], mosi}; bc++;
    if (bc == 8) begin log_b[log_n] = sh; log_f[log_n] = frame; log_n++; bc = 0; end
  end
  always @(negedge sclk) begin
    fe++;
    if (hi_run < hi_min) hi_min = hi_run;
    if (hi_run > hi_max) hi_max = hi_run;
    hi_run = 0;
  end
  always @(posedge clk) if (sclk) hi_run++;
  always_comb cur_b = pat(fe / 8);
  assign miso = cur_b[7 - (fe % 8)];

  // shadow configuration
  int sh_mode = 0, sh_seg = 24, sh_dum = 1;
  logic [7:0] sh_op = '0;
  bit sh_a4 = 0;

  logic [7:0]  exp_b [0:63];
  int          exp_f [0:63];
  int          exp_n;
  bit          exp_err;
  logic [31:0] exp_rd;

  task automatic chk(input bit ok, input string req_s, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req_s, what, act, expv);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; cfg_addr = 2'd0;
  endtask

  task automatic set_ctrl(input int md, input logic [7:0] op, input bit a4, input bit csoff);
    sh_mode = md; sh_op = op; sh_a4 = a4;
    cfg_wr(2'd0, (32'(op) << 16) | (32'(a4) << 13) | (32'(csoff) << 2) | 32'(md));
  endtask

  task automatic start_acc(input bit w, input logic [31:0] a, input logic [31:0] d, input int nb);
    @(negedge clk); req = 1'b1; we = w; addr = a; wdata = d; size = 2'(nb - 1);
    @(negedge clk); req = 1'b0;
  endtask

  task automatic build_exp(input bit w, input logic [31:0] a, input logic [31:0] d,
                           input int nb, input int base, input int fb);
    logic [31:0] ma;
    int k, f;
    bit mm;
    mm = (sh_mode != 3) && (w ? (sh_mode < 2) : (sh_mode == 2));
    ma = (sh_seg >= 32) ? a : (a & ((32'h1 << sh_seg) - 32'h1));
    exp_err = mm || (sh_mode != 3 && ma != a);
    exp_n = 0; exp_rd = '0;
    if (mm) return;
    k = 0; f = (sh_mode == 3) ? fb : fb + 1;
    if (sh_mode == 2) begin exp_b[k] = 8'h06; exp_f[k] = f; k++; f++; end
    if (sh_mode != 3) begin
      exp_b[k] = (sh_mode == 0) ? 8'h03 : sh_op; exp_f[k] = f; k++;
      for (int i = (sh_a4 ? 3 : 2); i >= 0; i--) begin exp_b[k] = ma[8*i +: 8]; exp_f[k] = f; k++; end
      if (sh_mode == 1) for (int i = 0; i < sh_dum; i++) begin exp_b[k] = 8'h00; exp_f[k] = f; k++; end
    end
    for (int i = 0; i < nb; i++) begin
      exp_b[k] = w ? d[8*i +: 8] : 8'h00; exp_f[k] = f;
      if (!w) exp_rd[8*i +: 8] = pat(base + k);
      k++;
    end
    exp_n = k;
  endtask

  task automatic run_chk(input bit w, input logic [31:0] a, input logic [31:0] d,
                         input int nb, input string req_s);
    int base, fb, bad_i;
    bit ok;
    base = log_n; fb = frame;
    build_exp(w, a, d, nb, base, fb);
    start_acc(w, a, d, nb);
    while (!ready) @(negedge clk);
    ok = ((log_n - base) == exp_n); bad_i = -1;
    if (ok) for (int i = 0; i < exp_n; i++)
      if (log_b[base + i] !== exp_b[i] || log_f[base + i] != exp_f[i]) begin
        ok = 0; if (bad_i < 0) bad_i = i;
      end
    chk(ok, req_s, "spi byte stream",
        (bad_i >= 0) ? 32'(log_b[base + bad_i]) : 32'(log_n - base),
        (bad_i >= 0) ? 32'(exp_b[bad_i]) : 32'(exp_n));
    chk(err == exp_err, req_s, "error flag", 32'(err), 32'(exp_err));
    if (!w && exp_n > 0) chk(rdata == exp_rd, req_s, "read data", rdata, exp_rd);
    if (sh_mode != 3 && exp_n > 0)
      chk(cs_n && cfg_rdata[2], req_s, "chip select released", {cs_n, cfg_rdata[2]}, 32'h3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ready && cs_n && !sclk && !err, "R1", "idle outputs", {ready, cs_n, sclk, err}, 32'hC);
    chk(cfg_rdata == 32'h4, "R1", "control reset", cfg_rdata, 32'h4);
    cfg_addr = 2'd1; #1; chk(cfg_rdata == 32'd24, "R1", "segment reset", cfg_rdata, 32'd24);
    cfg_addr = 2'd2; #1; chk(cfg_rdata == 32'd1, "R1", "divider reset", cfg_rdata, 32'd1);
    cfg_addr = 2'd3; #1; chk(cfg_rdata == 32'd1, "R1", "dummy reset", cfg_rdata, 32'd1);
    cfg_addr = 2'd0;

    // R2 normal read ignores opcode field; check mid-transaction (R10)
    set_ctrl(0, 8'hAB, 0, 1);
    run_chk(0, 32'h0012_3456, '0, 4, "R2");
    run_chk(0, 32'h00AB_CDEF, '0, 1, "R2");
    start_acc(0, 32'h0000_0100, '0, 2);
    repeat (3) @(negedge clk);
    chk(!ready, "R10", "ready low while busy", 32'(ready), 32'h0);
    chk(!cs_n && !cfg_rdata[2], "R2", "cs asserted in frame", {cs_n, cfg_rdata[2]}, 32'h0);
    while (!ready) @(negedge clk);
    chk(cs_n, "R10", "cs released at ready", 32'(cs_n), 32'h1);

    // R3 four-byte address
    set_ctrl(0, 8'h00, 1, 1);
    run_chk(0, 32'h00C1_D2E3, '0, 3, "R3");

    // R4 segment window
    cfg_wr(2'd1, 32'd16); sh_seg = 16;
    run_chk(0, 32'h0012_3456, '0, 2, "R4");
    run_chk(0, 32'h0000_3456, '0, 2, "R4");

    // R5 fast read with dummies
    set_ctrl(1, 8'h0B, 0, 1);
    cfg_wr(2'd3, 32'd2); sh_dum = 2;
    run_chk(0, 32'h0000_1234, '0, 4, "R5");
    cfg_wr(2'd3, 32'd0); sh_dum = 0;
    run_chk(0, 32'h0000_00FF, '0, 2, "R5");

    // R6 write with enable frame
    set_ctrl(2, 8'h02, 0, 1);
    run_chk(1, 32'h0000_4321, 32'hDEAD_BEEF, 4, "R6");
    set_ctrl(2, 8'h12, 1, 1);
    run_chk(1, 32'h0000_0010, 32'h0000_00A5, 1, "R6");

    // R8 wrong direction
    run_chk(0, 32'h0000_0010, '0, 2, "R8");
    set_ctrl(0, 8'h00, 0, 1);
    run_chk(1, 32'h0000_0010, 32'h1234_5678, 2, "R8");

    // R7 pass-through with software-held select
    set_ctrl(3, 8'h00, 0, 0);
    chk(!cs_n, "R7", "software select", 32'(cs_n), 32'h0);
    run_chk(1, 32'hFFFF_FFFF, 32'h0000_BEEF, 2, "R7");
    run_chk(0, 32'hFFFF_FFFF, '0, 3, "R7");
    chk(!cs_n, "R7", "select untouched", 32'(cs_n), 32'h0);
    set_ctrl(3, 8'h00, 0, 1);
    chk(cs_n, "R7", "software release", 32'(cs_n), 32'h1);

    // R9 divider
    cfg_wr(2'd2, 32'd3);
    set_ctrl(0, 8'h00, 0, 1);
    hi_min = 1000; hi_max = 0;
    run_chk(0, 32'h0000_0042, '0, 1, "R9");
    chk(hi_min == 4 && hi_max == 4, "R9", "sclk high length", 32'(hi_min), 32'd4);

    // random mix over command modes
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 40; it++) begin
      int md, sg, dv;
      md = $urandom_range(0, 2);
      sg = (it % 4 == 0) ? 32 : 12 + 4 * $urandom_range(0, 3);
      dv = $urandom_range(0, 2);
      cfg_wr(2'd1, 32'(sg)); sh_seg = sg;
      cfg_wr(2'd2, 32'(dv));
      sh_dum = $urandom_range(0, 3); cfg_wr(2'd3, 32'(sh_dum));
      set_ctrl(md, 8'($urandom), bit'($urandom_range(0, 1)), 1);
      run_chk(bit'($urandom_range(0, 1)), $urandom, $urandom, $urandom_range(1, 4),
              (md == 0) ? "R2" : (md == 1) ? "R5" : "R6");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule